// File: doc/BRIEF.md
# Multi-Level Radix Page Table Walker

This block translates an address by walking a radix page table held in memory. A walk starts from a root directory base, the index width of the root level and the size in bits of the whole address space. At each level the walker selects one 8-byte entry, reads it through a single memory read port, and decodes it. A directory entry supplies the base and index width of the next level. A leaf entry ends the walk and yields the translated address. Each level shrinks the remaining page size by the index width consumed there, so the depth at which the leaf is found sets the final page size.

Before every read, the walker checks that the level number, the current size and the index width form a legal tree shape. A shape that is not allowed ends the walk with a bad-configuration cause and no read for that level. An entry without its valid bit ends the walk with a missing-entry cause. A directory base that is not aligned to its table size is quietly realigned. The result, or the fault, is announced by a one-cycle done pulse. The result outputs then hold until the next walk starts.

The memory side is a valid/ready request channel carrying the entry address and a valid/ready response channel carrying the 64-bit entry. A request stays valid, with a stable address, until it is accepted. The response is taken only while the walker waits for it. Only one read is in flight at a time. The start strobe and the result pins are plain control and status.

Top module: `radix_walker`

## Requirements
- R1: After reset `busy`, `done`, `req_valid` and `rsp_ready` are 0, and the walker accepts `start` only while `busy` is 0.
- R2: The entry address at each level is the realigned base plus 8 times the index, where the index is (`va` >> (size - nls)) masked to its low nls bits. Every request address is a multiple of 8.
- R3: Before use, the root base and every next-level base have their low nls+3 bits cleared, where nls is that level's index width. The other bits are used unchanged.
- R4: Level 0 is legal only with size 52 and nls 13. Levels 1 and 2 need nls 9. Level 3 allows nls 9 or 5. Level 4 and deeper are never legal. An illegal level ends the walk with `cause` = 2'b10 and issues no read for that level.
- R5: An entry whose valid bit (bit 63) is 0 ends the walk with `cause` = 2'b01 after that read.
- R6: Entry layout: bit 63 valid, bit 62 leaf. In a directory entry, the next base is bits 55:8 with bits 7:0 as zero, and the next nls is bits 4:0. All other bits are ignored. After each valid entry is read, size is reduced by the nls of the level that was read.
- R7: On a leaf, `cause` = 2'b00. `page_size` is the reduced size. `real_addr` takes bits 55:12 of the entry above `page_size` and takes `va` below it. `leaf_pte` is the entry and `pte_addr` is its address.
- R8: `req_valid` stays high with `req_addr` unchanged until `req_ready`. `rsp_ready` is high only while a read is in flight. `req_valid` and `rsp_ready` are never high together.
- R9: Each accepted start produces exactly one single-cycle `done` pulse, with `busy` low in that cycle. The result outputs hold until the next start.
- R10: A `start` while `busy` is 1 is ignored, including in the cycle in which the final response is consumed. It causes no further read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| va | input | ADDR_W | Address to translate |
| root_base | input | ADDR_W | Root directory base |
| root_nls | input | NLS_W | Root index width |
| root_size | input | SIZE_W | Total address-space size in bits |
| busy | output | 1 | Walk in progress |
| req_valid | output | 1 | Entry read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | ADDR_W | Entry address |
| rsp_valid | input | 1 | Entry data valid |
| rsp_ready | output | 1 | Walker accepts the entry data |
| rsp_data | input | 64 | Entry read from memory |
| done | output | 1 | One-cycle completion pulse |
| cause | output | 2 | 00 ok, 01 missing entry, 10 bad configuration |
| real_addr | output | ADDR_W | Translated address |
| page_size | output | SIZE_W | Final page size in bits |
| leaf_pte | output | 64 | Leaf entry |
| pte_addr | output | ADDR_W | Address of the leaf entry |

## Verification
Two events can coincide: the response that completes a walk can arrive in the same cycle as a new `start`. The bench provokes this by raising `start` whenever a response is presented. It then checks that the first walk's results are correct and that no further request appears after `done`. Sweeps cover leaf depths 1 to 4, both legal last-level widths, misaligned bases, response latency and request back-pressure. Expected addresses and sizes are computed arithmetically in the bench.

// File: rtl/rwalk_pkg.sv
package rwalk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ISSUE,
    ST_WAIT
  } walk_state_t;

  localparam logic [1:0] CAUSE_OK     = 2'b00;
  localparam logic [1:0] CAUSE_NOPTE  = 2'b01;
  localparam logic [1:0] CAUSE_BADCFG = 2'b10;

  localparam int ENT_W         = 64;
  localparam int ENT_VALID_BIT = 63;
  localparam int ENT_LEAF_BIT  = 62;
  localparam int ENT_ADDR_HI   = 55;
  localparam int ENT_BASE_LO   = 8;
  localparam int ENT_RPN_LO    = 12;
  localparam int ENT_BYTES_LG  = 3;
endpackage

// File: rtl/rwalk_index.sv
module rwalk_index #(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 7,
  parameter int NLS_W  = 5
) (
  input  logic [ADDR_W-1:0] ea,
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] size,
  input  logic [NLS_W-1:0]  nls,
  output logic [ADDR_W-1:0] entry_addr
);
  import rwalk_pkg::*;

  localparam logic [ADDR_W-1:0] ONE_W = ADDR_W'(1);

  logic [ADDR_W-1:0] align_mask;
  logic [ADDR_W-1:0] idx_mask;
  logic [ADDR_W-1:0] aligned;
  logic [ADDR_W-1:0] shifted;
  logic [SIZE_W:0]   size_x;
  logic [SIZE_W:0]   nls_x;
  logic [SIZE_W:0]   shamt;

  always_comb begin
    size_x     = (SIZE_W+1)'(size);
    nls_x      = (SIZE_W+1)'(nls);
    // table of 2^nls entries of 8 bytes: clear the low nls+3 bits
    align_mask = (ONE_W << (32'(nls) + ENT_BYTES_LG)) - ONE_W;
    idx_mask   = (ONE_W << nls) - ONE_W;
    shamt      = (nls_x > size_x) ? '0 : (size_x - nls_x);
    shifted    = ea >> shamt;
    aligned    = base & ~align_mask;
    entry_addr = aligned + ((shifted & idx_mask) << ENT_BYTES_LG);
  end
endmodule

// File: rtl/rwalk_level_check.sv
module rwalk_level_check #(
  parameter int SIZE_W     = 7,
  parameter int NLS_W      = 5,
  parameter int LVL_W      = 3,
  parameter int ROOT_SIZE  = 52,
  parameter int ROOT_NLS   = 13,
  parameter int MID_NLS    = 9,
  parameter int ALT_NLS    = 5,
  parameter int LAST_LEVEL = 3
) (
  input  logic [LVL_W-1:0]  level,
  input  logic [SIZE_W-1:0] size,
  input  logic [NLS_W-1:0]  nls,
  output logic              legal
);
  localparam logic [SIZE_W-1:0] ROOT_SIZE_C = SIZE_W'(ROOT_SIZE);
  localparam logic [NLS_W-1:0]  ROOT_NLS_C  = NLS_W'(ROOT_NLS);
  localparam logic [NLS_W-1:0]  MID_NLS_C   = NLS_W'(MID_NLS);
  localparam logic [NLS_W-1:0]  ALT_NLS_C   = NLS_W'(ALT_NLS);
  localparam logic [LVL_W-1:0]  LAST_C      = LVL_W'(LAST_LEVEL);

  always_comb begin
    legal = 1'b0;
    if (level == '0) begin
      legal = (size == ROOT_SIZE_C) && (nls == ROOT_NLS_C);
    end else if (level < LAST_C) begin
      legal = (nls == MID_NLS_C);
    end else if (level == LAST_C) begin
      legal = (nls == MID_NLS_C) || (nls == ALT_NLS_C);
    end
  end
endmodule

// File: rtl/rwalk_entry_decode.sv
module rwalk_entry_decode #(
  parameter int ADDR_W = 64,
  parameter int NLS_W  = 5
) (
  input  logic [rwalk_pkg::ENT_W-1:0] entry,
  output logic                        ent_valid,
  output logic                        ent_leaf,
  output logic [ADDR_W-1:0]           next_base,
  output logic [NLS_W-1:0]            next_nls,
  output logic [ADDR_W-1:0]           rpn
);
  import rwalk_pkg::*;

  localparam int BASE_BITS = ENT_ADDR_HI - ENT_BASE_LO + 1;
  localparam int RPN_BITS  = ENT_ADDR_HI - ENT_RPN_LO + 1;

  always_comb begin
    ent_valid = entry[ENT_VALID_BIT];
    ent_leaf  = entry[ENT_LEAF_BIT];
    next_nls  = entry[NLS_W-1:0];
    next_base = ADDR_W'({entry[ENT_ADDR_HI:ENT_BASE_LO], ENT_BASE_LO'(0)});
    rpn       = ADDR_W'({entry[ENT_ADDR_HI:ENT_RPN_LO], ENT_RPN_LO'(0)});
  end

  if (BASE_BITS <= 0 || RPN_BITS <= 0 || ADDR_W < ENT_ADDR_HI + 1) begin : g_bad_cfg
    initial $error("rwalk_entry_decode: field layout does not fit ADDR_W");
  end
endmodule

// File: rtl/rwalk_compose.sv
module rwalk_compose #(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 7
) (
  input  logic [ADDR_W-1:0] rpn,
  input  logic [ADDR_W-1:0] ea,
  input  logic [SIZE_W-1:0] size,
  output logic [ADDR_W-1:0] real_addr
);
  localparam logic [ADDR_W-1:0] ONE_W = ADDR_W'(1);

  logic [ADDR_W-1:0] low_mask;

  always_comb begin
    low_mask  = (ONE_W << size) - ONE_W;
    real_addr = (rpn & ~low_mask) | (ea & low_mask);
  end
endmodule

// File: rtl/radix_walker.sv
module radix_walker #(
  parameter int ADDR_W     = 64,
  parameter int SIZE_W     = 7,
  parameter int NLS_W      = 5,
  parameter int ROOT_SIZE  = 52,
  parameter int ROOT_NLS   = 13,
  parameter int MID_NLS    = 9,
  parameter int ALT_NLS    = 5,
  parameter int LAST_LEVEL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] va,
  input  logic [ADDR_W-1:0] root_base,
  input  logic [NLS_W-1:0]  root_nls,
  input  logic [SIZE_W-1:0] root_size,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [63:0]       rsp_data,
  output logic              done,
  output logic [1:0]        cause,
  output logic [ADDR_W-1:0] real_addr,
  output logic [SIZE_W-1:0] page_size,
  output logic [63:0]       leaf_pte,
  output logic [ADDR_W-1:0] pte_addr
);
  import rwalk_pkg::*;

  localparam int LVL_W = $clog2(LAST_LEVEL + 2);

  walk_state_t       state_q;
  logic [ADDR_W-1:0] ea_q;
  logic [ADDR_W-1:0] base_q;
  logic [NLS_W-1:0]  nls_q;
  logic [SIZE_W-1:0] size_q;
  logic [LVL_W-1:0]  level_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;
  logic [1:0]        cause_q;
  logic [ADDR_W-1:0] ra_q;
  logic [SIZE_W-1:0] psize_q;
  logic [63:0]       pte_q;
  logic [ADDR_W-1:0] pteaddr_q;

  logic [ADDR_W-1:0] idx_addr;
  logic              lvl_legal;
  logic              ent_valid;
  logic              ent_leaf;
  logic [ADDR_W-1:0] ent_base;
  logic [NLS_W-1:0]  ent_nls;
  logic [ADDR_W-1:0] ent_rpn;
  logic [SIZE_W-1:0] size_after;
  logic [ADDR_W-1:0] leaf_ra;
  logic              rsp_fire;
  logic              req_fire;

  rwalk_index #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .NLS_W(NLS_W)) u_index (
    .ea        (ea_q),
    .base      (base_q),
    .size      (size_q),
    .nls       (nls_q),
    .entry_addr(idx_addr)
  );

  rwalk_level_check #(
    .SIZE_W(SIZE_W), .NLS_W(NLS_W), .LVL_W(LVL_W),
    .ROOT_SIZE(ROOT_SIZE), .ROOT_NLS(ROOT_NLS), .MID_NLS(MID_NLS),
    .ALT_NLS(ALT_NLS), .LAST_LEVEL(LAST_LEVEL)
  ) u_check (
    .level(level_q),
    .size (size_q),
    .nls  (nls_q),
    .legal(lvl_legal)
  );

  rwalk_entry_decode #(.ADDR_W(ADDR_W), .NLS_W(NLS_W)) u_decode (
    .entry    (rsp_data),
    .ent_valid(ent_valid),
    .ent_leaf (ent_leaf),
    .next_base(ent_base),
    .next_nls (ent_nls),
    .rpn      (ent_rpn)
  );

  assign size_after = size_q - SIZE_W'(nls_q);

  rwalk_compose #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_compose (
    .rpn      (ent_rpn),
    .ea       (ea_q),
    .size     (size_after),
    .real_addr(leaf_ra)
  );

  assign busy      = (state_q != ST_IDLE);
  assign req_valid = (state_q == ST_ISSUE);
  assign req_addr  = addr_q;
  assign rsp_ready = (state_q == ST_WAIT);
  assign req_fire  = req_valid && req_ready;
  assign rsp_fire  = rsp_valid && rsp_ready;

  assign done      = done_q;
  assign cause     = cause_q;
  assign real_addr = ra_q;
  assign page_size = psize_q;
  assign leaf_pte  = pte_q;
  assign pte_addr  = pteaddr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ea_q      <= '0;
      base_q    <= '0;
      nls_q     <= '0;
      size_q    <= '0;
      level_q   <= '0;
      addr_q    <= '0;
      done_q    <= 1'b0;
      cause_q   <= CAUSE_OK;
      ra_q      <= '0;
      psize_q   <= '0;
      pte_q     <= '0;
      pteaddr_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            ea_q    <= va;
            base_q  <= root_base;
            nls_q   <= root_nls;
            size_q  <= root_size;
            level_q <= '0;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (!lvl_legal) begin
            cause_q <= CAUSE_BADCFG;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            addr_q  <= idx_addr;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (req_fire) begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_fire) begin
            if (!ent_valid) begin
              cause_q <= CAUSE_NOPTE;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (ent_leaf) begin
              cause_q   <= CAUSE_OK;
              ra_q      <= leaf_ra;
              psize_q   <= size_after;
              pte_q     <= rsp_data;
              pteaddr_q <= addr_q;
              done_q    <= 1'b1;
              state_q   <= ST_IDLE;
            end else begin
              size_q  <= size_after;
              base_q  <= ent_base;
              nls_q   <= ent_nls;
              level_q <= level_q + LVL_W'(1);
              state_q <= ST_CHECK;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk #(
  parameter int ADDR_W    = 64,
  parameter int SIZE_W    = 7,
  parameter int ROOT_SIZE = 52
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              done,
  input logic [1:0]        cause,
  input logic [SIZE_W-1:0] page_size
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!req_valid && !rsp_ready));

  assert_entry_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[2:0] == 3'b000));

  assert_badcfg_no_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cause == 2'b10) |-> !$past(rsp_valid && rsp_ready));

  assert_nopte_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cause == 2'b01) |-> $past(rsp_valid && rsp_ready));

  assert_leaf_size_shrunk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cause == 2'b00) |-> (page_size < SIZE_W'(ROOT_SIZE)));

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  assert_one_in_flight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind radix_walker radix_walker_chk #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .ROOT_SIZE(ROOT_SIZE)
) u_chk (.*);

// File: tb/radix_walker_test.sv
`timescale 1ns/1ps
module radix_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_drv = 1'b0;
  logic        start_poke = 1'b0;
  logic        start;
  logic [63:0] va = '0;
  logic [63:0] root_base = '0;
  logic [4:0]  root_nls = '0;
  logic [6:0]  root_size = '0;
  logic        busy, req_valid, req_ready, rsp_ready, done;
  logic [63:0] req_addr, rsp_data, real_addr, leaf_pte, pte_addr;
  logic        rsp_valid;
  logic [1:0]  cause;
  logic [6:0]  page_size;

  always #2 clk = ~clk;
  assign start = start_drv | start_poke;

  radix_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .va(va), .root_base(root_base),
    .root_nls(root_nls), .root_size(root_size), .busy(busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .done(done), .cause(cause), .real_addr(real_addr), .page_size(page_size),
    .leaf_pte(leaf_pte), .pte_addr(pte_addr)
  );

  // memory model
  logic [63:0] mem [logic [63:0]];
  int          nreq = 0;
  int          cyc = 0;
  int          lat = 0;
  bit          stall_en = 1'b0;
  bit          poke_en = 1'b0;
  logic        pend = 1'b0;
  logic [63:0] paddr = '0;
  int          dly = 0;

  function automatic logic [63:0] mrd(input logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'd0;
  endfunction

  assign req_ready = !stall_en || cyc[0];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      pend      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (req_valid && req_ready) begin
        pend  <= 1'b1;
        paddr <= req_addr;
        dly   <= lat;
        nreq  <= nreq + 1;
      end
      if (pend && !rsp_valid) begin
        if (dly == 0) begin
          rsp_valid <= 1'b1;
          rsp_data  <= mrd(paddr);
          pend      <= 1'b0;
        end else begin
          dly <= dly - 1;
        end
      end
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
    end
  end

  // raise start while a response is presented (walker is busy then)
  always @(negedge clk) start_poke = poke_en && rsp_valid;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;
  task automatic rnd(output logic [63:0] r);
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    r = rs;
  endtask

  function automatic logic [63:0] ent_addr(input logic [63:0] ea, input logic [63:0] base,
                                           input int size, input int nls);
    logic [63:0] al, idx;
    al  = base & ~((64'd1 << (nls + 3)) - 64'd1);
    idx = (ea >> (size - nls)) & ((64'd1 << nls) - 64'd1);
    return al + idx * 64'd8;
  endfunction

  localparam logic [63:0] VBIT = 64'h8000_0000_0000_0000;
  localparam logic [63:0] LBIT = 64'h4000_0000_0000_0000;
  localparam logic [63:0] FLD  = 64'h00FF_FFFF_FFFF_FF00;

  logic [63:0] lvl_addr [0:4];
  logic [63:0] e_ra, e_pte, e_pa;
  int          e_size;

  task automatic build(input logic [63:0] ea, input logic [63:0] root, input int depth,
                       input int lastn, input bit misalign);
    logic [63:0] base, a, nb, e, r, mask;
    int size, nls, nn;
    base = root; size = 52; nls = 13;
    for (int lv = 0; lv < depth; lv++) begin
      a = ent_addr(ea, base, size, nls);
      lvl_addr[lv] = a;
      size = size - nls;
      rnd(r);
      if (lv == depth - 1) begin
        e = VBIT | LBIT | (r & 64'h00FF_FFFF_FFFF_F000) | 64'hABC;
        mem[a] = e;
        mask = (64'd1 << size) - 64'd1;
        e_pte = e; e_pa = a; e_size = size;
        e_ra = ((r & 64'h00FF_FFFF_FFFF_F000) & ~mask) | (ea & mask);
      end else begin
        nn = (lv == 2) ? lastn : 9;
        nb = (r & 64'h0000_FFFF_FFFF_F000) | (64'(lv + 1) << 48);
        if (misalign && nn == 9) nb = nb | 64'h900;
        // junk in ignored bits 58:56 and 7:5
        e = VBIT | (nb & FLD) | 64'(nn) | 64'h0700_0000_0000_00E0;
        mem[a] = e;
        base = nb; nls = nn;
      end
    end
  endtask

  logic [1:0]  g_cause;
  logic [63:0] g_ra, g_pte, g_pa;
  logic [6:0]  g_ps;
  int          g_reads;

  task automatic walk(input logic [63:0] ea, input logic [63:0] base, input int size,
                      input int nls);
    int n0;
    bit seen;
    @(negedge clk);
    va = ea; root_base = base; root_size = 7'(size); root_nls = 5'(nls);
    n0 = nreq;
    start_drv = 1'b1;
    @(negedge clk);
    start_drv = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    if (!seen) begin
      n_vec++; n_bad++;
      $display("FAIL R9 no done pulse actual=0 expected=1");
    end
    g_cause = cause; g_ra = real_addr; g_pte = leaf_pte; g_pa = pte_addr;
    g_ps = page_size; g_reads = nreq - n0;
  endtask

  task automatic expect_ok(input int depth);
    chk("R7 cause ok", 64'(g_cause), 64'd0);
    chk("R7 real_addr", g_ra, e_ra);
    chk("R6 page_size", 64'(g_ps), 64'(e_size));
    chk("R7 leaf_pte", g_pte, e_pte);
    chk("R2 pte_addr", g_pa, e_pa);
    chk("R8 read count", 64'(g_reads), 64'(depth));
  endtask

  task automatic expect_fault(input string tag, input logic [1:0] c, input int reads);
    chk(tag, 64'(cause), 64'(c));
    chk({tag, " reads"}, 64'(g_reads), 64'(reads));
  endtask

  initial begin
    #600000;
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] ea, root, sv_ra;
    int depth, lastn, n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", 64'(busy), 64'd0);
    chk("R1 done after reset", 64'(done), 64'd0);
    chk("R1 req_valid after reset", 64'(req_valid), 64'd0);
    chk("R1 rsp_ready after reset", 64'(rsp_ready), 64'd0);

    // sweep: leaf at each depth, both last-level widths, latency and back-pressure
    for (int cfg = 0; cfg < 5; cfg++) begin
      for (int k = 0; k < 24; k++) begin
        mem.delete();
        depth = (cfg == 4) ? 4 : cfg + 1;
        lastn = (cfg == 4) ? 5 : 9;
        lat = k % 3;
        stall_en = k[1];
        rnd(ea);
        rnd(root);
        root = (root & 64'h0000_00FF_FFFF_0000) | 64'h0001_0000_0000_0000;
        if (k[2]) root = root | 64'h1F08;   // R3 misaligned root base
        build(ea, root, depth, lastn, k[0]);
        walk(ea, root, 52, 13);
        expect_ok(depth);
      end
    end

    // R9: results hold after done
    sv_ra = g_ra;
    repeat (5) @(negedge clk);
    chk("R9 real_addr holds", real_addr, sv_ra);
    chk("R9 busy low after done", 64'(busy), 64'd0);

    // R5: missing entry at each level
    for (int lv = 0; lv < 4; lv++) begin
      mem.delete();
      rnd(ea);
      build(ea, 64'h0002_0000_0000_0000, 4, 9, 1'b0);
      mem.delete(lvl_addr[lv]);
      walk(ea, 64'h0002_0000_0000_0000, 52, 13);
      expect_fault("R5 nopte", 2'b01, lv + 1);
    end

    // R4: illegal shapes
    mem.delete();
    rnd(ea);
    build(ea, 64'h0003_0000_0000_0000, 4, 9, 1'b0);
    walk(ea, 64'h0003_0000_0000_0000, 48, 13);
    expect_fault("R4 root size 48", 2'b10, 0);
    walk(ea, 64'h0003_0000_0000_0000, 52, 12);
    expect_fault("R4 root nls 12", 2'b10, 0);
    mem[lvl_addr[0]] = (mem[lvl_addr[0]] & ~64'h1F) | 64'd8;
    walk(ea, 64'h0003_0000_0000_0000, 52, 13);
    expect_fault("R4 level1 nls 8", 2'b10, 1);

    mem.delete();
    build(ea, 64'h0003_0000_0000_0000, 4, 9, 1'b0);
    mem[lvl_addr[1]] = (mem[lvl_addr[1]] & ~64'h1F) | 64'd5;
    walk(ea, 64'h0003_0000_0000_0000, 52, 13);
    expect_fault("R4 level2 nls 5", 2'b10, 2);

    mem.delete();
    build(ea, 64'h0003_0000_0000_0000, 4, 9, 1'b0);
    mem[lvl_addr[2]] = (mem[lvl_addr[2]] & ~64'h1F) | 64'd7;
    walk(ea, 64'h0003_0000_0000_0000, 52, 13);
    expect_fault("R4 level3 nls 7", 2'b10, 3);

    mem.delete();
    build(ea, 64'h0003_0000_0000_0000, 4, 9, 1'b0);
    mem[lvl_addr[3]] = VBIT | 64'h0000_0044_0000_0000 | 64'd9;
    walk(ea, 64'h0003_0000_0000_0000, 52, 13);
    expect_fault("R4 level4 not allowed", 2'b10, 4);

    // R10: start raised during every response, including the final one
    for (int k = 0; k < 4; k++) begin
      mem.delete();
      rnd(ea);
      lat = k;
      build(ea, 64'h0004_0000_0000_0000, 4, (k % 2 == 0) ? 9 : 5, 1'b0);
      poke_en = 1'b1;
      walk(ea, 64'h0004_0000_0000_0000, 52, 13);
      poke_en = 1'b0;
      expect_ok(4);
      n0 = nreq;
      repeat (8) @(negedge clk);
      chk("R10 no read after ignored start", 64'(nreq - n0), 64'd0);
      chk("R10 idle after ignored start", 64'(busy), 64'd0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule